// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is the serial control port of a clock-generation chip. A host on a two-wire SMBus-style bus reaches a bank of 22 eight-bit configuration registers through it. Each register comes out of reset with its own default value, and the whole bank is presented in parallel on `cfg_o` for the logic that uses it. SCL and SDA are oversampled by the block clock. SDA is driven open-drain: `sda_oe` high pulls the line low. The block never holds SCL low.

The command byte sets the access mode. When bit 7 is set, the access is a single-byte access to the register whose index is in bits 6:0. When the command is 00h, the access is a block transfer that starts at register 0 and advances one register per data byte. A block write carries a byte count after the command, and the block ignores that count. A block read returns the register count (16h) first. Register 1 bits 4:0 are strap inputs that are captured once after reset. Registers 6 and 7 hold fixed identification values. Host writes cannot change any of these bits.

Top module: `smbcfg_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 69h (write byte D2h, read byte D3h). Any other address gets no ACK, and the block ignores the rest of that transfer until the next START.
- R2: After reset, registers 0..21 read 10h, {111b, strap}, FFh, EFh, BFh, 02h, 60h, 70h, 90h, 7Ah, BBh, 0Bh, FBh, 0Fh, 0Ah, 2Ch, 24h, 00h, 00h, D2h, 88h, 00h, and SDA is released.
- R3: A command byte with bit 7 = 1 is acknowledged and selects register bits 6:0. The next byte is written to that register and acknowledged. Any later data byte in the same transfer is not acknowledged and is discarded.
- R4: Byte read: after a byte-mode command, a repeated START and the read address, the block returns the selected register's current value.
- R5: Block write: command 00h, then a count byte that is acknowledged and ignored, then data bytes written to registers 0, 1, 2, and so on. The index saturates at 21, so every byte past the 22nd overwrites register 21.
- R6: Block read: after command 00h and a repeated START with the read address, the first byte returned is 16h. Registers 0, 1, 2, and so on follow, and once the index reaches 21 it stays there for every further byte the host acknowledges.
- R7: A command byte with bit 7 = 0 and a nonzero value is not acknowledged. The block ignores the rest of that transfer, including any data bytes.
- R8: Registers 6 and 7 keep 60h and 70h, and register 1 bits 4:0 keep the captured strap levels, whatever the host writes. Register 1 bits 7:5 are writable.
- R9: A byte-mode command that selects an index above 21 is acknowledged. A write to that index changes no register, and a read returns 00h.
- R10: `sda_oe` changes only while SCL is low.
- R11: A STOP (SDA rising while SCL is high) ends the transfer and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| strap_i | input | 5 | Strap levels captured once after reset into register 1 bits 4:0 |
| cfg_o | output | 176 | All 22 registers as seen by the host; register n is in bits 8n+7:8n |

## Verification
The line inputs pass through two synchronizer flops. A register write therefore appears on `cfg_o` at the third rising clock edge after SCL rises for the eighth bit of a data byte. The bench changes its reference register array at that exact edge and compares the two on every falling clock edge. ACK and read-data bits appear on `sda_oe` three clocks after an SCL falling edge. The bench holds SCL low for at least eleven clocks before raising it and samples SDA in the middle of the high phase, so each acknowledge and each read bit is checked well after it becomes valid.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int IDX_W     = 7;
    localparam int NUM_REGS  = 22;
    localparam int STRAP_W   = 5;
    localparam int STRAP_REG = 1;
    localparam int ID_REG_A  = 6;
    localparam int ID_REG_B  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_st_e;

    typedef enum logic [2:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA,
        PH_DONE
    } rx_ph_e;

    // Power-up value of each register.
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            0:  return 8'h10;
            1:  return 8'hE2;
            2:  return 8'hFF;
            3:  return 8'hEF;
            4:  return 8'hBF;
            5:  return 8'h02;
            6:  return 8'h60;
            7:  return 8'h70;
            8:  return 8'h90;
            9:  return 8'h7A;
            10: return 8'hBB;
            11: return 8'h0B;
            12: return 8'hFB;
            13: return 8'h0F;
            14: return 8'h0A;
            15: return 8'h2C;
            16: return 8'h24;
            19: return 8'hD2;
            20: return 8'h88;
            default: return 8'h00;
        endcase
    endfunction

    // Bits the host may change in each register.
    function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
        if (idx == ID_REG_A || idx == ID_REG_B)
            return '0;
        else if (idx == STRAP_REG)
            return BYTE_W'(8'hFF << STRAP_W);
        else
            return '1;
    endfunction

endpackage

// File: rtl/smbcfg_linesync.sv
module smbcfg_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES:0] scl_d, scl_q;
    logic [STAGES:0] sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[STAGES-1:0], scl_i};
        sda_d = {sda_q[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    // Index STAGES-1 is the synchronized level, STAGES the one before it.
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  =  scl_q[STAGES-1] & ~scl_q[STAGES];
    assign scl_fall  = ~scl_q[STAGES-1] &  scl_q[STAGES];
    assign start_det =  scl_q[STAGES-1] &  scl_q[STAGES] & sda_q[STAGES] & ~sda_q[STAGES-1];
    assign stop_det  =  scl_q[STAGES-1] &  scl_q[STAGES] & ~sda_q[STAGES] & sda_q[STAGES-1];

endmodule

// File: rtl/smbcfg_regbank.sv
module smbcfg_regbank
    import smbcfg_pkg::*;
#(
    parameter int NREGS = NUM_REGS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic [STRAP_W-1:0]      strap_i,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [BYTE_W-1:0]       rd_data,
    output logic [NREGS*BYTE_W-1:0] cfg_o
);

    logic [BYTE_W-1:0]  mem_d [NREGS];
    logic [BYTE_W-1:0]  mem_q [NREGS];
    logic [BYTE_W-1:0]  view  [NREGS];
    logic [STRAP_W-1:0] strap_d, strap_q;
    logic               strap_vld_d, strap_vld_q;

    always_comb begin
        mem_d       = mem_q;
        strap_d     = strap_q;
        strap_vld_d = strap_vld_q;
        if (!strap_vld_q) begin
            strap_d     = strap_i;
            strap_vld_d = 1'b1;
        end
        if (wr_en) begin
            for (int i = 0; i < NREGS; i++) begin
                if (wr_idx == IDX_W'(i))
                    mem_d[i] = (mem_q[i] & ~reg_wmask(i)) | (wr_data & reg_wmask(i));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++)
                mem_q[i] <= reg_default(i);
            strap_q     <= '0;
            strap_vld_q <= 1'b0;
        end else begin
            mem_q       <= mem_d;
            strap_q     <= strap_d;
            strap_vld_q <= strap_vld_d;
        end
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_view
        if (g == STRAP_REG) begin : g_strap
            assign view[g] = {mem_q[g][BYTE_W-1:STRAP_W], strap_q};
        end else begin : g_plain
            assign view[g] = mem_q[g];
        end
        assign cfg_o[g*BYTE_W +: BYTE_W] = view[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_data = view[i];
        end
    end

endmodule

// File: rtl/smbcfg_slave.sv
module smbcfg_slave
    import smbcfg_pkg::*;
#(
    parameter int         NREGS    = NUM_REGS,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    input  logic [STRAP_W-1:0]      strap_i,
    output logic [NREGS*BYTE_W-1:0] cfg_o
);

    localparam logic [IDX_W-1:0]     LAST_IDX = IDX_W'(NREGS - 1);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0]    CNT_BYTE = BYTE_W'(NREGS);

    typedef struct packed {
        bus_st_e              st;
        rx_ph_e               ph;
        logic [BYTE_W-1:0]    sh;
        logic [BIT_CNT_W-1:0] bcnt;
        logic                 oe;
        logic                 ack;
        logic                 drv;
        logic                 to_tx;
        logic                 blk;
        logic                 cnt_pend;
        logic [IDX_W-1:0]     idx;
    } fsm_t;

    fsm_t st_d, st_q;

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] rx_byte, rd_data, tx_byte;
    logic              ld_inc;

    smbcfg_linesync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smbcfg_regbank #(.NREGS(NREGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (rx_byte),
        .strap_i (strap_i),
        .rd_idx  (st_q.idx),
        .rd_data (rd_data),
        .cfg_o   (cfg_o)
    );

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_idx  = st_q.idx;
        rx_byte = {st_q.sh[BYTE_W-2:0], sda_s};
        tx_byte = st_q.cnt_pend ? CNT_BYTE : rd_data;
        ld_inc  = !st_q.cnt_pend && st_q.blk && (st_q.idx != LAST_IDX);

        if (start_det) begin
            st_d.st   = ST_RX;
            st_d.ph   = PH_ADDR;
            st_d.bcnt = '0;
            st_d.oe   = 1'b0;
            st_d.drv  = 1'b0;
            st_d.ack  = 1'b0;
        end else if (stop_det) begin
            st_d.st  = ST_IDLE;
            st_d.oe  = 1'b0;
            st_d.drv = 1'b0;
        end else begin
            case (st_q.st)
                ST_RX: if (scl_rise) begin
                    st_d.sh   = rx_byte;
                    st_d.bcnt = st_q.bcnt + 1'b1;
                    if (st_q.bcnt == LAST_BIT) begin
                        st_d.st    = ST_RX_ACK;
                        st_d.drv   = 1'b0;
                        st_d.to_tx = 1'b0;
                        st_d.ack   = 1'b0;
                        case (st_q.ph)
                            PH_ADDR: if (rx_byte[7:1] == DEV_ADDR) begin
                                st_d.ack = 1'b1;
                                if (rx_byte[0]) begin
                                    st_d.to_tx    = 1'b1;
                                    st_d.cnt_pend = st_q.blk;
                                    if (st_q.blk) st_d.idx = '0;
                                end else begin
                                    st_d.ph = PH_CMD;
                                end
                            end
                            PH_CMD: begin
                                if (rx_byte[7]) begin
                                    st_d.blk = 1'b0;
                                    st_d.idx = rx_byte[IDX_W-1:0];
                                    st_d.ack = 1'b1;
                                    st_d.ph  = PH_DATA;
                                end else if (rx_byte[IDX_W-1:0] == '0) begin
                                    st_d.blk = 1'b1;
                                    st_d.idx = '0;
                                    st_d.ack = 1'b1;
                                    st_d.ph  = PH_CNT;
                                end else begin
                                    st_d.ph  = PH_DONE;
                                end
                            end
                            PH_CNT: begin
                                st_d.ack = 1'b1;
                                st_d.ph  = PH_DATA;
                            end
                            PH_DATA: begin
                                st_d.ack = 1'b1;
                                wr_en    = 1'b1;
                                if (st_q.blk) begin
                                    if (st_q.idx != LAST_IDX) st_d.idx = st_q.idx + 1'b1;
                                end else begin
                                    st_d.ph = PH_DONE;
                                end
                            end
                            default: st_d.ack = 1'b0;
                        endcase
                    end
                end
                ST_RX_ACK: if (scl_fall) begin
                    if (!st_q.drv) begin
                        if (st_q.ack) begin
                            st_d.oe  = 1'b1;
                            st_d.drv = 1'b1;
                        end else begin
                            st_d.st = ST_IDLE;
                        end
                    end else begin
                        st_d.drv  = 1'b0;
                        st_d.bcnt = '0;
                        if (st_q.to_tx) begin
                            st_d.st       = ST_TX;
                            st_d.sh       = tx_byte;
                            st_d.oe       = ~tx_byte[BYTE_W-1];
                            st_d.cnt_pend = 1'b0;
                            if (ld_inc) st_d.idx = st_q.idx + 1'b1;
                        end else begin
                            st_d.st = ST_RX;
                            st_d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (st_q.bcnt == LAST_BIT) begin
                        st_d.oe  = 1'b0;
                        st_d.st  = ST_TX_ACK;
                        st_d.ack = 1'b0;
                    end else begin
                        st_d.sh   = {st_q.sh[BYTE_W-2:0], 1'b0};
                        st_d.bcnt = st_q.bcnt + 1'b1;
                        st_d.oe   = ~st_q.sh[BYTE_W-2];
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) st_d.st  = ST_IDLE;
                        else       st_d.ack = 1'b1;
                    end else if (scl_fall && st_q.ack) begin
                        st_d.st       = ST_TX;
                        st_d.bcnt     = '0;
                        st_d.sh       = tx_byte;
                        st_d.oe       = ~tx_byte[BYTE_W-1];
                        st_d.cnt_pend = 1'b0;
                        if (ld_inc) st_d.idx = st_q.idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, ph: PH_ADDR, sh: '0, bcnt: '0, oe: 1'b0,
                      ack: 1'b0, drv: 1'b0, to_tx: 1'b0, blk: 1'b0,
                      cnt_pend: 1'b0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe = st_q.oe;

endmodule

// File: rtl/smbcfg_slave_chk.sv
module smbcfg_slave_chk
    import smbcfg_pkg::*;
#(
    parameter int NREGS = NUM_REGS
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_i,
    input logic                    sda_oe,
    input logic                    stop_det,
    input logic                    wr_en,
    input logic [IDX_W-1:0]        wr_idx,
    input logic                    blk,
    input logic [IDX_W-1:0]        idx,
    input logic [NREGS*BYTE_W-1:0] cfg_o
);

    // R10: the data line is only switched while the clock line is low
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R11: a detected STOP leaves SDA released
    a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R5: the block index never runs past the last register
    a_r5_block_idx_sat: assert property (@(posedge clk) disable iff (!rst_n)
        blk |-> (idx < IDX_W'(NREGS)));

    // R8: identification registers ignore write strobes
    a_r8_id_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IDX_W'(ID_REG_A) || wr_idx == IDX_W'(ID_REG_B)))
        |=> $stable(cfg_o[ID_REG_A*BYTE_W +: 2*BYTE_W]));

    // R9: a write strobe beyond the bank changes nothing
    a_r9_oob_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_W'(NREGS)) |=> $stable(cfg_o));

endmodule

bind smbcfg_slave smbcfg_slave_chk #(.NREGS(NREGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .stop_det (stop_det),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .blk      (st_q.blk),
    .idx      (st_q.idx),
    .cfg_o    (cfg_o)
);

// File: tb/smbcfg_slave_test.sv
module smbcfg_slave_test;

    localparam int NR   = 22;
    localparam int HALF = 8;
    localparam logic [4:0] STRAP = 5'b10110;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic            sda_oe;
    logic            sda_line;
    logic [NR*8-1:0] cfg_o;

    int   model [NR];
    int   nchk = 0, nfail = 0;
    bit   cmp_en = 1'b0, done = 1'b0;
    int   mm_cnt = 0, mm_act = 0, mm_exp = 0;
    bit   pend_wr = 1'b0;
    int   pend_idx = 0, pend_val = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    smbcfg_slave uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap_i (STRAP),
        .cfg_o   (cfg_o)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Reference bank: defaults, write masks and bank size come from R2, R8, R9
    task automatic model_init();
        int dflt [NR] = '{8'h10, 8'hE2, 8'hFF, 8'hEF, 8'hBF, 8'h02, 8'h60, 8'h70,
                          8'h90, 8'h7A, 8'hBB, 8'h0B, 8'hFB, 8'h0F, 8'h0A, 8'h2C,
                          8'h24, 8'h00, 8'h00, 8'hD2, 8'h88, 8'h00};
        for (int i = 0; i < NR; i++) model[i] = dflt[i];
        model[1] = {3'b111, STRAP};
    endtask

    task automatic model_wr(input int idx, input int val);
        if (idx >= NR || idx == 6 || idx == 7) return;
        if (idx == 1) model[1] = {val[7:5], STRAP};
        else          model[idx] = val & 8'hFF;
    endtask

    // Per-clock comparison of the register bank against the reference
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            for (int i = 0; i < NR; i++) begin
                if (int'(cfg_o[i*8 +: 8]) != model[i]) begin
                    if (mm_cnt == 0) begin
                        mm_act = int'(cfg_o[i*8 +: 8]);
                        mm_exp = model[i];
                    end
                    mm_cnt++;
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(2*HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            wait_clk(HALF);
            scl_m = 1'b1;
            if (i == 0 && pend_wr) begin
                repeat (3) @(posedge clk);
                model_wr(pend_idx, pend_val);
                pend_wr = 1'b0;
                @(negedge clk);
                wait_clk(HALF - 4);
            end else begin
                wait_clk(HALF);
            end
            scl_m = 1'b0;
            wait_clk(3);
        end
        sda_m = 1'b1;
        wait_clk(HALF);
        scl_m = 1'b1;
        wait_clk(HALF/2);
        acked = !sda_line;
        wait_clk(HALF/2);
        scl_m = 1'b0;
        wait_clk(3);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(HALF);
            scl_m = 1'b1;
            wait_clk(HALF/2);
            b[i] = sda_line;
            wait_clk(HALF/2);
            scl_m = 1'b0;
            wait_clk(3);
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        wait_clk(HALF);
        scl_m = 1'b1;
        wait_clk(HALF);
        scl_m = 1'b0;
        wait_clk(3);
        sda_m = 1'b1;
    endtask

    task automatic wr_byte(input int idx, input int val);
        bit a;
        bus_start();
        send_byte(8'hD2, a); check(a, "R1 write address ack", a, 1);
        send_byte(8'h80 | idx[6:0], a); check(a, "R3 byte command ack", a, 1);
        pend_wr = 1'b1; pend_idx = idx; pend_val = val;
        send_byte(val[7:0], a); check(a, "R3 byte data ack", a, 1);
        bus_stop();
    endtask

    task automatic rd_byte(input int idx, output logic [7:0] v);
        bit a;
        bus_start();
        send_byte(8'hD2, a); check(a, "R1 write address ack", a, 1);
        send_byte(8'h80 | idx[6:0], a); check(a, "R4 byte command ack", a, 1);
        bus_rstart();
        send_byte(8'hD3, a); check(a, "R1 read address ack", a, 1);
        recv_byte(v, 1'b0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit a;
        model_init();
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        cmp_en = 1'b1;

        // R2: reset values and released line
        for (int i = 0; i < NR; i++)
            check(int'(cfg_o[i*8 +: 8]) == model[i], "R2 reset value", int'(cfg_o[i*8 +: 8]), model[i]);
        check(sda_oe == 1'b0, "R2 SDA released after reset", sda_oe, 0);

        // R3: byte write, second data byte refused
        bus_start();
        send_byte(8'hD2, a); check(a, "R1 address ack", a, 1);
        send_byte(8'h88, a); check(a, "R3 command ack", a, 1);
        pend_wr = 1'b1; pend_idx = 8; pend_val = 8'h5A;
        send_byte(8'h5A, a); check(a, "R3 data ack", a, 1);
        send_byte(8'h33, a); check(!a, "R3 extra byte nack", a, 0);
        bus_stop();
        check(sda_oe == 1'b0, "R11 SDA released after STOP", sda_oe, 0);

        // R4: byte reads
        rd_byte(8, v);  check(v == 8'h5A, "R4 read reg8", v, 8'h5A);
        rd_byte(2, v);  check(v == 8'hFF, "R4 read reg2 default", v, 8'hFF);
        wr_byte(20, 8'hC3);
        rd_byte(20, v); check(v == 8'hC3, "R4 read back reg20", v, 8'hC3);

        // R1: foreign address ignored
        bus_start();
        send_byte(8'hA0, a); check(!a, "R1 foreign address nack", a, 0);
        send_byte(8'h80, a); check(!a, "R1 ignored after foreign address", a, 0);
        send_byte(8'h99, a); check(!a, "R1 data ignored", a, 0);
        bus_stop();
        rd_byte(0, v); check(v == model[0], "R1 reg0 untouched", v, model[0]);

        // R5: short block write
        bus_start();
        send_byte(8'hD2, a); check(a, "R1 address ack", a, 1);
        send_byte(8'h00, a); check(a, "R5 block command ack", a, 1);
        send_byte(8'h03, a); check(a, "R5 count ack", a, 1);
        for (int k = 0; k < 3; k++) begin
            pend_wr = 1'b1; pend_idx = k; pend_val = 8'h11 * (k + 1);
            send_byte(8'(8'h11 * (k + 1)), a); check(a, "R5 block data ack", a, 1);
        end
        bus_stop();

        // R5 / R8: long block write saturating on the last register
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a); check(a, "R5 block command ack", a, 1);
        send_byte(8'd24, a);
        for (int k = 0; k < 24; k++) begin
            pend_wr = 1'b1; pend_idx = (k > 21) ? 21 : k; pend_val = 8'h40 + k;
            send_byte(8'(8'h40 + k), a); check(a, "R5 saturating data ack", a, 1);
        end
        bus_stop();
        check(int'(cfg_o[21*8 +: 8]) == 8'h57, "R5 last register holds final byte", int'(cfg_o[21*8 +: 8]), 8'h57);
        check(int'(cfg_o[6*8 +: 8]) == 8'h60, "R8 reg6 after block write", int'(cfg_o[6*8 +: 8]), 8'h60);
        check(int'(cfg_o[1*8 +: 8]) == {3'b010, STRAP}, "R8 reg1 strap bits kept", int'(cfg_o[1*8 +: 8]), {3'b010, STRAP});

        // R6: block read with count byte and saturation
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a); check(a, "R6 block command ack", a, 1);
        bus_rstart();
        send_byte(8'hD3, a); check(a, "R1 read address ack", a, 1);
        recv_byte(v, 1'b1); check(v == 8'h16, "R6 count byte", v, 8'h16);
        for (int k = 0; k < 24; k++) begin
            recv_byte(v, k != 23);
            check(int'(v) == model[(k > 21) ? 21 : k], "R6 block read data", v, model[(k > 21) ? 21 : k]);
        end
        bus_stop();

        // R7: bad block command refused, following data discarded
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h05, a); check(!a, "R7 nonzero block command nack", a, 0);
        send_byte(8'h77, a); check(!a, "R7 data after refusal nack", a, 0);
        bus_stop();

        // R8: read-only registers and fields
        wr_byte(6, 8'hAA);
        rd_byte(6, v); check(v == 8'h60, "R8 reg6 read-only", v, 8'h60);
        wr_byte(7, 8'h01);
        rd_byte(7, v); check(v == 8'h70, "R8 reg7 read-only", v, 8'h70);
        wr_byte(1, 8'h0F);
        rd_byte(1, v); check(v == {3'b000, STRAP}, "R8 reg1 strap field", v, {3'b000, STRAP});

        // R9: index beyond the bank
        wr_byte(30, 8'hEE);
        rd_byte(30, v); check(v == 8'h00, "R9 out-of-range read", v, 8'h00);
        rd_byte(22, v); check(v == 8'h00, "R9 first index past bank", v, 8'h00);

        wait_clk(4);
        check(mm_cnt == 0, "R3 R5 R8 R9 per-clock register model", mm_act, mm_exp);
        check(sda_oe == 1'b0, "R11 SDA released at end", sda_oe, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule